// File: doc/BRIEF.md
# Pipeline Forwarding and Stall Control

This block is the hazard controller for a five-stage in-order pipeline (fetch, decode, execute, memory access, writeback) whose instructions name two source registers and one destination. Each cycle it compares the source registers of the instruction in the execute stage with the destinations of the two older instructions ahead of it. From that it chooses, for each ALU operand, whether the value comes from the register file, from the memory-stage latch or from the writeback-stage latch. Both bypass paths may hold a matching value. When they do, the younger producer wins.

The block also compares the sources of the instruction in decode with the destination of a load in the execute stage. A loaded value exists only after the memory access, so that pairing cannot be covered by forwarding. The block holds the program counter and the fetch/decode latch for one cycle and writes a bubble into the decode/execute latch. Finally, it flags each decode operand whose register is being written in writeback during the same cycle, so that the register read returns the new value.

The control is purely combinational. The clock and reset inputs only time the embedded property checks.

Top module: `hazard_fwd_ctrl`

## Requirements
- R1: Each execute operand has its own 2-bit select. The encoding is 00 for the register file value, 01 for the memory-stage result and 10 for the writeback-stage result. The value 11 never appears.
- R2: If the memory-stage instruction writes a register (write enable set, not a load) equal to an execute source, that operand's select is 01.
- R3: If the writeback-stage instruction writes a register equal to an execute source, and the memory stage does not claim that operand, the select is 10.
- R4: If both the memory stage and the writeback stage match one source, the memory stage (the younger producer) is chosen, giving 01.
- R5: A match counts only when the producer's write enable is set. Register 0 is an ordinary register and is forwarded like any other.
- R6: A load in the memory stage whose destination matches an execute source never supplies that operand. It also masks any older writeback match, so the select is 00.
- R7: If the execute-stage instruction is a load with write enable set and its destination equals either decode source, the fetch hold and the bubble insert are both 1. Otherwise both are 0.
- R8: When the pipeline obeys the hold, a load-use pair costs exactly one stall cycle. The stall output is never high on two consecutive cycles.
- R9: A decode operand's writeback bypass flag is 1 exactly when the writeback instruction has write enable set and its destination equals that decode source.
- R10: A pipeline driven by these controls produces the same register contents as sequential execution. The sequence load r1; mul r2,r1,r1; load r3; mul r4,r3,r3; add r5,r2,r4 costs exactly two stall cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the property checks |
| rst | input | 1 | Synchronous active-high reset; disables the checks |
| id_src_i | input | NUM_SRC x AW | Source register indices of the decode-stage instruction |
| ex_src_i | input | NUM_SRC x AW | Source register indices of the execute-stage instruction |
| ex_dst_i | input | AW | Destination of the execute-stage instruction |
| ex_wen_i | input | 1 | Execute-stage instruction writes a register |
| ex_load_i | input | 1 | Execute-stage instruction is a load |
| mem_dst_i | input | AW | Destination of the memory-stage instruction |
| mem_wen_i | input | 1 | Memory-stage instruction writes a register |
| mem_load_i | input | 1 | Memory-stage instruction is a load |
| wb_dst_i | input | AW | Destination of the writeback-stage instruction |
| wb_wen_i | input | 1 | Writeback-stage instruction writes a register |
| ex_fwd_sel_o | output | NUM_SRC x 2 | Per-operand bypass select for the execute stage |
| id_wb_byp_o | output | NUM_SRC | Per-operand writeback-to-decode bypass flag |
| fetch_hold_o | output | 1 | Hold the program counter and the fetch/decode latch |
| idex_bubble_o | output | 1 | Load a bubble into the decode/execute latch |

## Verification
The bench builds the block with NUM_REGS = 8 and NUM_SRC = 2. With only eight registers, random register picks collide often, so a few hundred random instructions reach the double-match priority case, masking by a memory-stage load, register-0 producers and back-to-back load-use pairs. The two-source setting matches the three-operand instruction format. A bench pipeline uses the block's own selects and bypass flags to move data. Any wrong choice therefore shows up in the final register contents, and the stall count is checked as well.

// File: rtl/hfc_pkg.sv
`timescale 1ns/1ps
package hfc_pkg;

    // Operand source choice for an execute-stage ALU input
    typedef enum logic [1:0] {
        SEL_RF    = 2'b00,
        SEL_EXMEM = 2'b01,
        SEL_MEMWB = 2'b10
    } fwd_sel_e;

    // Comparison outcome for one operand against the two producers
    typedef struct packed {
        logic near_hit;   // memory-stage ALU producer matches
        logic near_block; // memory-stage load matches (data not ready)
        logic far_hit;    // writeback-stage producer matches
    } hit_vec_t;

    // Younger producer ranks first; a matching load shadows older data
    function automatic fwd_sel_e rank_sources(hit_vec_t h);
        if (h.near_hit)   return SEL_EXMEM;
        if (h.near_block) return SEL_RF;
        if (h.far_hit)    return SEL_MEMWB;
        return SEL_RF;
    endfunction

endpackage

// File: rtl/hfc_operand_fwd.sv
`timescale 1ns/1ps
module hfc_operand_fwd
    import hfc_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] mem_dst_i,
    input  logic          mem_wen_i,
    input  logic          mem_load_i,
    input  logic [AW-1:0] wb_dst_i,
    input  logic          wb_wen_i,
    output fwd_sel_e      sel_o
);

    hit_vec_t hits;
    logic     mem_match;
    logic     wb_match;

    always_comb begin
        mem_match       = mem_wen_i && (mem_dst_i == src_i);
        wb_match        = wb_wen_i && (wb_dst_i == src_i);
        hits.near_hit   = mem_match && !mem_load_i;
        hits.near_block = mem_match && mem_load_i;
        hits.far_hit    = wb_match;
        sel_o           = rank_sources(hits);
    end

    assert_sel_legal_R1: assert property (@(posedge clk) disable iff (rst)
        sel_o != 2'b11);

    assert_near_wins_R2: assert property (@(posedge clk) disable iff (rst)
        (mem_wen_i && !mem_load_i && mem_dst_i == src_i) |-> sel_o == SEL_EXMEM);

    assert_far_only_R3: assert property (@(posedge clk) disable iff (rst)
        (sel_o == SEL_MEMWB) |-> (wb_wen_i && wb_dst_i == src_i &&
                                  !(mem_wen_i && mem_dst_i == src_i)));

    assert_priority_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_wen_i && !mem_load_i && mem_dst_i == src_i && wb_wen_i && wb_dst_i == src_i)
            |-> sel_o != SEL_MEMWB);

    assert_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (!mem_wen_i && !wb_wen_i) |-> sel_o == SEL_RF);

    assert_load_mask_R6: assert property (@(posedge clk) disable iff (rst)
        (mem_wen_i && mem_load_i && mem_dst_i == src_i) |-> sel_o == SEL_RF);

endmodule

// File: rtl/hfc_load_use.sv
`timescale 1ns/1ps
module hfc_load_use #(
    parameter int AW      = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NUM_SRC-1:0][AW-1:0] id_src_i,
    input  logic [AW-1:0]           ex_dst_i,
    input  logic                    ex_wen_i,
    input  logic                    ex_load_i,
    output logic                    stall_o
);

    logic [NUM_SRC-1:0] src_hit;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_cmp
        assign src_hit[k] = (id_src_i[k] == ex_dst_i);
    end

    always_comb begin
        stall_o = ex_load_i && ex_wen_i && (|src_hit);
    end

    assert_stall_cause_R7: assert property (@(posedge clk) disable iff (rst)
        stall_o |-> (ex_load_i && ex_wen_i));

    assert_stall_single_R8: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> !stall_o);

endmodule

// File: rtl/hfc_rf_bypass.sv
`timescale 1ns/1ps
module hfc_rf_bypass #(
    parameter int AW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] wb_dst_i,
    input  logic          wb_wen_i,
    output logic          byp_o
);

    always_comb begin
        byp_o = wb_wen_i && (wb_dst_i == src_i);
    end

    assert_byp_cause_R9: assert property (@(posedge clk) disable iff (rst)
        byp_o |-> (wb_wen_i && wb_dst_i == src_i));

    assert_byp_needed_R9: assert property (@(posedge clk) disable iff (rst)
        (wb_wen_i && wb_dst_i == src_i) |-> byp_o);

endmodule

// File: rtl/hazard_fwd_ctrl.sv
`timescale 1ns/1ps
module hazard_fwd_ctrl
    import hfc_pkg::*;
#(
    parameter int NUM_REGS = 32,
    parameter int NUM_SRC  = 2,
    localparam int AW      = $clog2(NUM_REGS)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [NUM_SRC-1:0][AW-1:0] id_src_i,
    input  logic [NUM_SRC-1:0][AW-1:0] ex_src_i,
    input  logic [AW-1:0]              ex_dst_i,
    input  logic                       ex_wen_i,
    input  logic                       ex_load_i,
    input  logic [AW-1:0]              mem_dst_i,
    input  logic                       mem_wen_i,
    input  logic                       mem_load_i,
    input  logic [AW-1:0]              wb_dst_i,
    input  logic                       wb_wen_i,
    output logic [NUM_SRC-1:0][1:0]    ex_fwd_sel_o,
    output logic [NUM_SRC-1:0]         id_wb_byp_o,
    output logic                       fetch_hold_o,
    output logic                       idex_bubble_o
);

    logic load_use;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_opnd
        fwd_sel_e sel_k;

        hfc_operand_fwd #(.AW(AW)) u_fwd (
            .clk        (clk),
            .rst        (rst),
            .src_i      (ex_src_i[k]),
            .mem_dst_i  (mem_dst_i),
            .mem_wen_i  (mem_wen_i),
            .mem_load_i (mem_load_i),
            .wb_dst_i   (wb_dst_i),
            .wb_wen_i   (wb_wen_i),
            .sel_o      (sel_k)
        );

        assign ex_fwd_sel_o[k] = sel_k;

        hfc_rf_bypass #(.AW(AW)) u_byp (
            .clk      (clk),
            .rst      (rst),
            .src_i    (id_src_i[k]),
            .wb_dst_i (wb_dst_i),
            .wb_wen_i (wb_wen_i),
            .byp_o    (id_wb_byp_o[k])
        );
    end

    hfc_load_use #(.AW(AW), .NUM_SRC(NUM_SRC)) u_lu (
        .clk       (clk),
        .rst       (rst),
        .id_src_i  (id_src_i),
        .ex_dst_i  (ex_dst_i),
        .ex_wen_i  (ex_wen_i),
        .ex_load_i (ex_load_i),
        .stall_o   (load_use)
    );

    assign fetch_hold_o  = load_use;
    assign idex_bubble_o = load_use;

    assert_hold_bubble_R7: assert property (@(posedge clk) disable iff (rst)
        fetch_hold_o == idex_bubble_o);

endmodule

// File: tb/hazard_fwd_ctrl_tb_top.sv
`timescale 1ns/1ps
module hazard_fwd_ctrl_tb_top;

    localparam int NR = 8;
    localparam int NS = 2;
    localparam int AW = 3;
    localparam int PMAX = 256;

    typedef enum logic [1:0] {OP_NOP, OP_ALU, OP_MUL, OP_LD} op_e;
    typedef struct packed {
        op_e           op;
        logic [AW-1:0] rd;
        logic [AW-1:0] ra;
        logic [AW-1:0] rb;
    } ins_t;
    typedef struct packed {
        ins_t        ins;
        logic [31:0] va;
        logic [31:0] vb;
        logic [31:0] res;
    } stg_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic [NS-1:0][AW-1:0] d_id_src, d_ex_src;
    logic [AW-1:0] d_ex_dst, d_mem_dst, d_wb_dst;
    logic d_ex_wen, d_ex_load, d_mem_wen, d_mem_load, d_wb_wen;
    logic [NS-1:0][1:0] sel;
    logic [NS-1:0] byp;
    logic hold, bubble;

    hazard_fwd_ctrl #(.NUM_REGS(NR), .NUM_SRC(NS)) dut_i (
        .clk(clk), .rst(rst),
        .id_src_i(d_id_src), .ex_src_i(d_ex_src),
        .ex_dst_i(d_ex_dst), .ex_wen_i(d_ex_wen), .ex_load_i(d_ex_load),
        .mem_dst_i(d_mem_dst), .mem_wen_i(d_mem_wen), .mem_load_i(d_mem_load),
        .wb_dst_i(d_wb_dst), .wb_wen_i(d_wb_wen),
        .ex_fwd_sel_o(sel), .id_wb_byp_o(byp),
        .fetch_hold_o(hold), .idex_bubble_o(bubble)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    ins_t prog [PMAX];
    logic [31:0] rf [NR];
    logic [31:0] rf_g [NR];
    stg_t s_id, s_ex, s_mem, s_wb;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ld_data(logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h00005A5A;
    endfunction

    function automatic logic [1:0] exp_sel(logic [AW-1:0] s, ins_t m, ins_t w);
        if (m.op != OP_NOP && m.rd == s) return (m.op == OP_LD) ? 2'b00 : 2'b01;
        if (w.op != OP_NOP && w.rd == s) return 2'b10;
        return 2'b00;
    endfunction

    function automatic logic exp_stall(ins_t d, ins_t e);
        return (e.op == OP_LD) && (e.rd == d.ra || e.rd == d.rb);
    endfunction

    function automatic logic [31:0] alu(op_e op, logic [31:0] a, logic [31:0] b);
        case (op)
            OP_ALU:  return a + b;
            OP_MUL:  return a * b;
            OP_LD:   return a + b;
            default: return 32'h0;
        endcase
    endfunction

    task automatic clr_drive();
        d_id_src = '0; d_ex_src = '0;
        d_ex_dst = '0; d_mem_dst = '0; d_wb_dst = '0;
        d_ex_wen = 0; d_ex_load = 0; d_mem_wen = 0; d_mem_load = 0; d_wb_wen = 0;
    endtask

    task automatic drive_from_stages();
        d_id_src[0] = s_id.ins.ra;  d_id_src[1] = s_id.ins.rb;
        d_ex_src[0] = s_ex.ins.ra;  d_ex_src[1] = s_ex.ins.rb;
        d_ex_dst  = s_ex.ins.rd;  d_ex_wen  = (s_ex.ins.op != OP_NOP);  d_ex_load  = (s_ex.ins.op == OP_LD);
        d_mem_dst = s_mem.ins.rd; d_mem_wen = (s_mem.ins.op != OP_NOP); d_mem_load = (s_mem.ins.op == OP_LD);
        d_wb_dst  = s_wb.ins.rd;  d_wb_wen  = (s_wb.ins.op != OP_NOP);
    endtask

    // Run a program through the bench pipeline; n instructions in prog[0..n-1]
    task automatic run_prog(input int n, input int exp_stalls_given, input string tag);
        int pc = 0;
        int stalls = 0;
        int exp_stalls = 0;
        logic prev_stall = 0;
        for (int i = 0; i < NR; i++) begin
            rf[i] = 32'(i * 3 + 1);
            rf_g[i] = rf[i];
        end
        for (int i = n; i < PMAX; i++) prog[i] = '0;
        for (int i = 0; i < n; i++) begin
            if (prog[i].op != OP_NOP)
                rf_g[prog[i].rd] = (prog[i].op == OP_LD)
                    ? ld_data(rf_g[prog[i].ra] + rf_g[prog[i].rb])
                    : alu(prog[i].op, rf_g[prog[i].ra], rf_g[prog[i].rb]);
        end
        for (int i = 1; i <= n; i++)
            if (exp_stall(prog[i], prog[i-1])) exp_stalls++;
        s_id = '0; s_ex = '0; s_mem = '0; s_wb = '0;
        for (int cyc = 0; cyc < n * 2 + 8; cyc++) begin
            logic [31:0] opa, opb, id_a, id_b;
            stg_t nwb, nmem, nex;
            @(posedge clk); #1;
            drive_from_stages();
            @(negedge clk);
            chk("R2/R3/R4/R6 operand a", {30'b0, sel[0]}, {30'b0, exp_sel(s_ex.ins.ra, s_mem.ins, s_wb.ins)});
            chk("R2/R3/R4/R6 operand b", {30'b0, sel[1]}, {30'b0, exp_sel(s_ex.ins.rb, s_mem.ins, s_wb.ins)});
            chk("R7 hold", {31'b0, hold}, {31'b0, exp_stall(s_id.ins, s_ex.ins)});
            chk("R7 bubble", {31'b0, bubble}, {31'b0, exp_stall(s_id.ins, s_ex.ins)});
            chk("R9 bypass a", {31'b0, byp[0]}, {31'b0, (s_wb.ins.op != OP_NOP && s_wb.ins.rd == s_id.ins.ra)});
            chk("R8 single stall", {31'b0, prev_stall & hold}, 32'h0);
            prev_stall = hold;
            if (hold) stalls++;
            opa = (sel[0] == 2'b01) ? s_mem.res : (sel[0] == 2'b10) ? s_wb.res : s_ex.va;
            opb = (sel[1] == 2'b01) ? s_mem.res : (sel[1] == 2'b10) ? s_wb.res : s_ex.vb;
            id_a = byp[0] ? s_wb.res : rf[s_id.ins.ra];
            id_b = byp[1] ? s_wb.res : rf[s_id.ins.rb];
            if (s_wb.ins.op != OP_NOP) rf[s_wb.ins.rd] = s_wb.res;
            nwb = s_mem;
            if (s_mem.ins.op == OP_LD) nwb.res = ld_data(s_mem.res);
            nmem = s_ex;
            nmem.res = alu(s_ex.ins.op, opa, opb);
            if (hold) begin
                nex = '0;
            end else begin
                nex = '0;
                nex.ins = s_id.ins; nex.va = id_a; nex.vb = id_b;
                s_id = '0;
                s_id.ins = prog[pc];
                if (pc < PMAX - 1) pc++;
            end
            s_wb = nwb; s_mem = nmem; s_ex = nex;
        end
        for (int i = 0; i < NR; i++) chk({"R10 register file ", tag}, rf[i], rf_g[i]);
        chk({"R10 stall count ", tag}, 32'(stalls), 32'(exp_stalls));
        if (exp_stalls_given >= 0) chk({"R10 stall count given ", tag}, 32'(stalls), 32'(exp_stalls_given));
    endtask

    task automatic apply_and_settle();
        @(negedge clk);
    endtask

    initial begin
        clr_drive();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset sel", {28'b0, sel}, 32'h0);
        chk("R7 reset hold", {31'b0, hold}, 32'h0);
        @(posedge clk); #1;
        rst = 0;

        // R5: all write enables low
        clr_drive(); d_ex_src[0] = 3; d_ex_src[1] = 3; d_mem_dst = 3; d_wb_dst = 3;
        apply_and_settle();
        chk("R5 no wen a", {30'b0, sel[0]}, 32'h0);
        chk("R5 no wen b", {30'b0, sel[1]}, 32'h0);

        // R2: memory-stage ALU producer on operand a only
        @(posedge clk); #1; clr_drive();
        d_ex_src[0] = 3; d_ex_src[1] = 4; d_mem_dst = 3; d_mem_wen = 1;
        apply_and_settle();
        chk("R2 near a", {30'b0, sel[0]}, 32'h1);
        chk("R2 other b", {30'b0, sel[1]}, 32'h0);

        // R3: writeback producer on operand b
        @(posedge clk); #1; clr_drive();
        d_ex_src[1] = 4; d_wb_dst = 4; d_wb_wen = 1;
        apply_and_settle();
        chk("R3 far b", {30'b0, sel[1]}, 32'h2);

        // R4: both match, younger wins
        @(posedge clk); #1; clr_drive();
        d_ex_src[0] = 5; d_mem_dst = 5; d_mem_wen = 1; d_wb_dst = 5; d_wb_wen = 1;
        apply_and_settle();
        chk("R4 priority", {30'b0, sel[0]}, 32'h1);

        // R5: register 0 forwarded like any other
        @(posedge clk); #1; clr_drive();
        d_ex_src[0] = 0; d_ex_src[1] = 1; d_mem_dst = 0; d_mem_wen = 1;
        apply_and_settle();
        chk("R5 reg0 forwarded", {30'b0, sel[0]}, 32'h1);

        // R6: memory-stage load masks older writeback match
        @(posedge clk); #1; clr_drive();
        d_ex_src[0] = 2; d_ex_src[1] = 1; d_mem_dst = 2; d_mem_wen = 1; d_mem_load = 1;
        d_wb_dst = 2; d_wb_wen = 1;
        apply_and_settle();
        chk("R6 load mask", {30'b0, sel[0]}, 32'h0);

        // R7: load-use on second decode source
        @(posedge clk); #1; clr_drive();
        d_id_src[0] = 7; d_id_src[1] = 6; d_ex_dst = 6; d_ex_wen = 1; d_ex_load = 1;
        apply_and_settle();
        chk("R7 load-use hold", {31'b0, hold}, 32'h1);
        chk("R7 load-use bubble", {31'b0, bubble}, 32'h1);

        // R7: same match but not a load
        @(posedge clk); #1; d_ex_load = 0;
        apply_and_settle();
        chk("R7 alu no stall", {31'b0, hold}, 32'h0);

        // R9: writeback to decode bypass on operand a only
        @(posedge clk); #1; clr_drive();
        d_id_src[0] = 1; d_id_src[1] = 2; d_wb_dst = 1; d_wb_wen = 1;
        apply_and_settle();
        chk("R9 bypass a", {31'b0, byp[0]}, 32'h1);
        chk("R9 bypass b", {31'b0, byp[1]}, 32'h0);

        // R10: directed sequence
        prog[0] = '{OP_LD,  3'd1, 3'd6, 3'd7};
        prog[1] = '{OP_MUL, 3'd2, 3'd1, 3'd1};
        prog[2] = '{OP_LD,  3'd3, 3'd6, 3'd0};
        prog[3] = '{OP_MUL, 3'd4, 3'd3, 3'd3};
        prog[4] = '{OP_ALU, 3'd5, 3'd2, 3'd4};
        run_prog(5, 2, "directed");

        // Constrained random stream
        void'($urandom(32'd2024));
        for (int r = 0; r < 3; r++) begin
            for (int i = 0; i < 200; i++) begin
                int w = int'($urandom_range(0, 9));
                if (w == 9) prog[i] = '0;
                else begin
                    prog[i].op = (w < 3) ? OP_LD : (w < 6) ? OP_ALU : OP_MUL;
                    prog[i].rd = AW'($urandom_range(0, NR - 1));
                    prog[i].ra = AW'($urandom_range(0, NR - 1));
                    prog[i].rb = AW'($urandom_range(0, NR - 1));
                end
            end
            run_prog(200, -1, "random");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule